// File: doc/BRIEF.md
# Eight-Pin GPIO Bank with Edge Interrupts and Timer Trigger Taps

This block gives a processor control of a bank of general-purpose pins through a plain register read/write port. Each pin can be driven as an output or left as an input. For outputs, software either writes the whole output data word or uses a set/clear word. The set/clear word raises and lowers individual pins in a single write, so no read-modify-write is needed. Software can load the output data word while the pin is still an input, so the pin drives the intended level from its first cycle as an output.

Each input pin passes through a synchronizer that is clocked only while that pin's interrupt or trigger function is enabled. The synchronized level feeds two things. The first is an edge detector: per pin, it sets a pending bit on a selectable rising or falling edge. All pending bits are ORed onto one interrupt line. Reading the status word returns the pending bits and clears them. The second is a trigger tap that passes the synchronized level on to an external timer.

Top module: `gpio_edge_bank`

## Requirements
- R1: `padOe[i]` equals bit i of the direction word (offset 0). A 1 drives pin i. The new value appears after the clock edge that takes the write.
- R2: The output data word (offset 1) holds the output level. `padOut` always shows it, whether or not the pin is driven. It is kept unchanged while the pin is an input, and it reads back at offset 1.
- R3: A write to offset 2 sets output bits where write bits [7:0] are 1 and clears output bits where write bits [23:16] are 1. Clear wins when both are 1. Bits that are 0 leave the output unchanged. Offset 2 reads as 0.
- R4: A pin can set its pending bit only while its direction bit is 0 and its interrupt-enable bit (offset 3) is 1.
- R5: The edge-select bit (offset 4) chooses the edge: 0 means rising, 1 means falling. The pending bit is set at the third clock edge after the pad changes. `irqOut` is the OR of all pending bits.
- R6: A read of offset 6 returns the pending bits and clears all of them. An edge detected in the same cycle as the read stays pending.
- R7: `trigOut[i]` is the synchronized level of pin i while the pin is an input and its trigger-enable bit (offset 5) is 1. Otherwise it is 0. It follows the pad two clock edges after the pad changes.
- R8: A pin's synchronizer flops update only while its interrupt or trigger enable is set. Otherwise they hold their old value. A pad change made while the pin was disabled therefore shows up as an edge once the pin is enabled.
- R9: Reset clears every register, so all pins start as inputs with interrupts and triggers off. Offsets 0, 1, 3, 4 and 5 read back the last value written. Read data appears on `busRdData` after the clock edge that samples `busRdEn`. Offset 7 reads as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busWrEn | input | 1 | Register write strobe |
| busRdEn | input | 1 | Register read strobe |
| busAddr | input | 3 | Register offset |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data, registered |
| padIn | input | 8 | Pin input levels from the pads |
| padOut | output | 8 | Pin output levels |
| padOe | output | 8 | Pin output enables |
| trigOut | output | 8 | Synchronized per-pin timer trigger levels |
| irqOut | output | 1 | Combined interrupt line |

## Verification
Each result is due a fixed number of cycles after its stimulus:

| Result | Due after |
|--------|-----------|
| Register write effects on `padOe` and `padOut` | the clock edge that takes the write |
| Read data | the edge that samples the read strobe |
| Trigger levels | the second edge after a pad change |
| Pending bits and `irqOut` | the third edge after a pad change |

The bench drives and samples only on falling clock edges and counts rising edges to reach each of these points. When a result should be absent, it waits well past the third edge. The read that coincides with an edge is placed so the read edge is exactly the third edge after the pad change. This checks both the returned word and the pending bit that survives.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;
  localparam int ADDR_W  = 3;
  localparam int DATA_W  = 32;
  localparam int SET_LSB = 0;
  localparam int CLR_LSB = 16;

  localparam logic [ADDR_W-1:0] OFS_DIR    = 3'd0;
  localparam logic [ADDR_W-1:0] OFS_OUT    = 3'd1;
  localparam logic [ADDR_W-1:0] OFS_SETCLR = 3'd2;
  localparam logic [ADDR_W-1:0] OFS_IRQEN  = 3'd3;
  localparam logic [ADDR_W-1:0] OFS_EDGE   = 3'd4;
  localparam logic [ADDR_W-1:0] OFS_TRIGEN = 3'd5;
  localparam logic [ADDR_W-1:0] OFS_STATUS = 3'd6;

  typedef struct packed {
    logic              wrDir;
    logic              wrOut;
    logic              wrSetClr;
    logic              wrIrqEn;
    logic              wrEdge;
    logic              wrTrig;
    logic              rdEn;
    logic              rdStatus;
    logic [ADDR_W-1:0] rdSel;
  } ctrlStrobes_t;
endpackage

// File: rtl/gpio_edge_sync.sv
module gpio_edge_sync (
  input  logic clk,
  input  logic rstN,
  input  logic en,
  input  logic padBit,
  output logic syncLvl,
  output logic rise,
  output logic fall
);
  logic stage1, stage2, prevLvl;

  // Flops advance only while the pin's trigger or interrupt function is on
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage1  <= 1'b0;
      stage2  <= 1'b0;
      prevLvl <= 1'b0;
    end else if (en) begin
      stage1  <= padBit;
      stage2  <= stage1;
      prevLvl <= stage2;
    end
  end

  assign syncLvl = stage2;
  assign rise    = stage2 & ~prevLvl;
  assign fall    = ~stage2 & prevLvl;
endmodule

// File: rtl/gpio_edge_ctrl.sv
module gpio_edge_ctrl
  import gpio_edge_pkg::*;
(
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [ADDR_W-1:0] busAddr,
  output ctrlStrobes_t      strobes
);
  always_comb begin
    strobes          = '0;
    strobes.rdEn     = busRdEn;
    strobes.rdSel    = busAddr;
    strobes.rdStatus = busRdEn && (busAddr == OFS_STATUS);
    if (busWrEn) begin
      case (busAddr)
        OFS_DIR:    strobes.wrDir    = 1'b1;
        OFS_OUT:    strobes.wrOut    = 1'b1;
        OFS_SETCLR: strobes.wrSetClr = 1'b1;
        OFS_IRQEN:  strobes.wrIrqEn  = 1'b1;
        OFS_EDGE:   strobes.wrEdge   = 1'b1;
        OFS_TRIGEN: strobes.wrTrig   = 1'b1;
        default:    ;
      endcase
    end
  end
endmodule

// File: rtl/gpio_edge_datapath.sv
module gpio_edge_datapath
  import gpio_edge_pkg::*;
#(
  parameter int NUM_PINS = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrlStrobes_t        strobes,
  input  logic [DATA_W-1:0]   busWrData,
  output logic [DATA_W-1:0]   busRdData,
  input  logic [NUM_PINS-1:0] padIn,
  output logic [NUM_PINS-1:0] padOut,
  output logic [NUM_PINS-1:0] padOe,
  output logic [NUM_PINS-1:0] trigOut,
  output logic                irqOut,
  output logic [NUM_PINS-1:0] dirVec,
  output logic [NUM_PINS-1:0] irqEnVec,
  output logic [NUM_PINS-1:0] hitVec
);
  logic [NUM_PINS-1:0] dirReg, outReg, irqEnReg, edgeReg, trigReg, statusReg;
  logic [NUM_PINS-1:0] syncLvl, riseVec, fallVec;
  logic [NUM_PINS-1:0] setBits, clrBits;
  logic [DATA_W-1:0]   rdMux;

  assign setBits = busWrData[SET_LSB +: NUM_PINS];
  assign clrBits = busWrData[CLR_LSB +: NUM_PINS];

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    gpio_edge_sync u_sync (
      .clk     (clk),
      .rstN    (rstN),
      .en      (irqEnReg[p] | trigReg[p]),
      .padBit  (padIn[p]),
      .syncLvl (syncLvl[p]),
      .rise    (riseVec[p]),
      .fall    (fallVec[p])
    );
    assign hitVec[p]  = irqEnReg[p] & ~dirReg[p] & (edgeReg[p] ? fallVec[p] : riseVec[p]);
    assign trigOut[p] = syncLvl[p] & trigReg[p] & ~dirReg[p];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dirReg   <= '0;
      outReg   <= '0;
      irqEnReg <= '0;
      edgeReg  <= '0;
      trigReg  <= '0;
    end else begin
      if (strobes.wrDir)    dirReg   <= busWrData[NUM_PINS-1:0];
      if (strobes.wrIrqEn)  irqEnReg <= busWrData[NUM_PINS-1:0];
      if (strobes.wrEdge)   edgeReg  <= busWrData[NUM_PINS-1:0];
      if (strobes.wrTrig)   trigReg  <= busWrData[NUM_PINS-1:0];
      if (strobes.wrOut)         outReg <= busWrData[NUM_PINS-1:0];
      else if (strobes.wrSetClr) outReg <= (outReg | setBits) & ~clrBits;
    end
  end

  // Clear-on-read keeps any edge that lands in the read cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) statusReg <= '0;
    else       statusReg <= (strobes.rdStatus ? '0 : statusReg) | hitVec;
  end

  always_comb begin
    rdMux = '0;
    case (strobes.rdSel)
      OFS_DIR:    rdMux[NUM_PINS-1:0] = dirReg;
      OFS_OUT:    rdMux[NUM_PINS-1:0] = outReg;
      OFS_IRQEN:  rdMux[NUM_PINS-1:0] = irqEnReg;
      OFS_EDGE:   rdMux[NUM_PINS-1:0] = edgeReg;
      OFS_TRIGEN: rdMux[NUM_PINS-1:0] = trigReg;
      OFS_STATUS: rdMux[NUM_PINS-1:0] = statusReg;
      default:    rdMux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             busRdData <= '0;
    else if (strobes.rdEn) busRdData <= rdMux;
  end

  assign padOut   = outReg;
  assign padOe    = dirReg;
  assign irqOut   = |statusReg;
  assign dirVec   = dirReg;
  assign irqEnVec = irqEnReg;
endmodule

// File: rtl/gpio_edge_bank.sv
module gpio_edge_bank
  import gpio_edge_pkg::*;
#(
  parameter int NUM_PINS = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                busWrEn,
  input  logic                busRdEn,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic [DATA_W-1:0]   busWrData,
  output logic [DATA_W-1:0]   busRdData,
  input  logic [NUM_PINS-1:0] padIn,
  output logic [NUM_PINS-1:0] padOut,
  output logic [NUM_PINS-1:0] padOe,
  output logic [NUM_PINS-1:0] trigOut,
  output logic                irqOut
);
  ctrlStrobes_t        strobes;
  logic [NUM_PINS-1:0] dirVec, irqEnVec, hitVec;

  gpio_edge_ctrl u_ctrl (
    .busWrEn (busWrEn),
    .busRdEn (busRdEn),
    .busAddr (busAddr),
    .strobes (strobes)
  );

  gpio_edge_datapath #(.NUM_PINS(NUM_PINS)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .busWrData (busWrData),
    .busRdData (busRdData),
    .padIn     (padIn),
    .padOut    (padOut),
    .padOe     (padOe),
    .trigOut   (trigOut),
    .irqOut    (irqOut),
    .dirVec    (dirVec),
    .irqEnVec  (irqEnVec),
    .hitVec    (hitVec)
  );
endmodule

// File: rtl/gpio_edge_bank_checker.sv
module gpio_edge_bank_checker
  import gpio_edge_pkg::*;
#(
  parameter int NUM_PINS = 8
) (
  input logic                clk,
  input logic                rstN,
  input logic                busWrEn,
  input logic                busRdEn,
  input logic [ADDR_W-1:0]   busAddr,
  input logic [DATA_W-1:0]   busWrData,
  input logic [NUM_PINS-1:0] padOut,
  input logic [NUM_PINS-1:0] padOe,
  input logic                irqOut,
  input logic [NUM_PINS-1:0] dirVec,
  input logic [NUM_PINS-1:0] irqEnVec,
  input logic [NUM_PINS-1:0] hitVec
);
  p_dir_drives_oe_r1: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == OFS_DIR) |=> (padOe == $past(busWrData[NUM_PINS-1:0])));

  p_setclr_update_r3: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == OFS_SETCLR) |=>
      (padOut == (($past(padOut) | $past(busWrData[SET_LSB +: NUM_PINS]))
                  & ~$past(busWrData[CLR_LSB +: NUM_PINS]))));

  p_irq_needs_enable_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqOut) |-> ($past(irqEnVec & ~dirVec) != '0));

  p_read_clears_r6: assert property (@(posedge clk) disable iff (!rstN)
    (busRdEn && busAddr == OFS_STATUS && hitVec == '0) |=> !irqOut);

  p_hold_out_r2: assert property (@(posedge clk) disable iff (!rstN)
    !busWrEn |=> $stable(padOut));
endmodule

bind gpio_edge_bank gpio_edge_bank_checker #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .busWrEn   (busWrEn),
  .busRdEn   (busRdEn),
  .busAddr   (busAddr),
  .busWrData (busWrData),
  .padOut    (padOut),
  .padOe     (padOe),
  .irqOut    (irqOut),
  .dirVec    (dirVec),
  .irqEnVec  (irqEnVec),
  .hitVec    (hitVec)
);

// File: tb/gpio_edge_bank_test.sv
module gpio_edge_bank_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWrEn = 1'b0;
  logic        busRdEn = 1'b0;
  logic [2:0]  busAddr = '0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic [7:0]  padIn = '0;
  logic [7:0]  padOut, padOe, trigOut;
  logic        irqOut;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  gpio_edge_bank uut (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busRdEn(busRdEn),
    .busAddr(busAddr), .busWrData(busWrData), .busRdData(busRdData),
    .padIn(padIn), .padOut(padOut), .padOe(padOe), .trigOut(trigOut),
    .irqOut(irqOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] setClrModel(logic [7:0] cur, logic [31:0] d);
    return (cur | d[7:0]) & ~d[23:16];
  endfunction

  function automatic logic [7:0] hitModel(logic [7:0] prevP, logic [7:0] curP,
                                          logic [7:0] edgeSel, logic [7:0] en,
                                          logic [7:0] dir);
    return en & ~dir & ((~edgeSel & ~prevP & curP) | (edgeSel & prevP & ~curP));
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  task automatic busWrite(logic [2:0] a, logic [31:0] d);
    busWrEn = 1'b1; busAddr = a; busWrData = d;
    @(posedge clk); @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic busRead(logic [2:0] a, output logic [31:0] d);
    busRdEn = 1'b1; busAddr = a;
    @(posedge clk); @(negedge clk);
    busRdEn = 1'b0;
    d = busRdData;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    logic [31:0] rd;
    logic [7:0] expOut, expDir, edgeSel, padPrev, expHit;
    void'($urandom(32'h5eed_1234));
    idle(3);
    rstN = 1'b1;
    idle(1);

    // R9 reset state
    check("R9 padOe reset", padOe, 0);
    check("R9 padOut reset", padOut, 0);
    check("R9 irqOut reset", irqOut, 0);
    check("R9 trigOut reset", trigOut, 0);
    for (int a = 0; a < 8; a++) begin
      busRead(a[2:0], rd);
      check("R9 register reset", rd, 0);
    end

    // R2 load output while input, R1 then switch to output
    busWrite(3'd1, 32'hA5);
    check("R2 output held while input", padOut, 8'hA5);
    check("R1 still input", padOe, 0);
    busRead(3'd1, rd);
    check("R2 output readback", rd, 32'hA5);
    busWrite(3'd0, 32'hFF);
    check("R1 direction drives oe", padOe, 8'hFF);
    check("R2 level after turn-on", padOut, 8'hA5);
    busRead(3'd0, rd);
    check("R9 dir readback", rd, 32'hFF);

    // R3 set/clear with overlap: clear wins
    busWrite(3'd2, 32'h0003_000F);
    check("R3 set clear overlap", padOut, 8'hAC);
    busRead(3'd2, rd);
    check("R3 setclr reads zero", rd, 0);

    // Random register writes against model
    expOut = 8'hAC; expDir = 8'hFF;
    for (int i = 0; i < 150; i++) begin
      logic [31:0] d;
      int sel;
      d = $urandom; sel = $urandom_range(0, 2);
      if (sel == 0) begin busWrite(3'd1, d); expOut = d[7:0]; end
      else if (sel == 1) begin busWrite(3'd2, d); expOut = setClrModel(expOut, d); end
      else begin busWrite(3'd0, d); expDir = d[7:0]; end
      check("R3 random output", padOut, expOut);
      check("R1 random direction", padOe, expDir);
    end

    // Random edge interrupts with all pins as inputs
    busWrite(3'd0, 0);
    padIn = 8'h00; padPrev = 8'h00;
    busWrite(3'd3, 32'hFF);
    idle(4);
    busRead(3'd6, rd);
    for (int i = 0; i < 40; i++) begin
      logic [7:0] np;
      edgeSel = $urandom;
      busWrite(3'd4, {24'd0, edgeSel});
      np = $urandom;
      padIn = np;
      idle(5);
      expHit = hitModel(padPrev, np, edgeSel, 8'hFF, 8'h00);
      padPrev = np;
      check("R5 irq is OR of pending", irqOut, expHit != 0);
      busRead(3'd6, rd);
      check("R5 edge-selected pending", rd, expHit);
      busRead(3'd6, rd);
      check("R6 read clears status", rd, 0);
      check("R6 irq low after clear", irqOut, 0);
    end

    // R4 gating by direction and enable
    busWrite(3'd4, 0);
    busWrite(3'd0, 32'h30);
    padIn = 8'h00; idle(5);
    busRead(3'd6, rd);
    busWrite(3'd3, 32'h3F);
    busRead(3'd6, rd);
    padIn = 8'hFF; idle(5);
    busRead(3'd6, rd);
    check("R4 only enabled input pins pend", rd, 32'h0F);

    // R7 trigger tap
    busWrite(3'd3, 0);
    busWrite(3'd5, 32'hC3);
    idle(3);
    check("R7 trigger follows synced pad", trigOut, 8'hC3);
    padIn = 8'h00;
    idle(1);
    check("R7 trigger one edge after change", trigOut, 8'hC3);
    idle(1);
    check("R7 trigger two edges after change", trigOut, 8'h00);
    padIn = 8'hFF;
    busWrite(3'd5, 32'h30);
    idle(4);
    check("R7 trigger masked on outputs", trigOut, 8'h00);
    busWrite(3'd5, 0);
    busWrite(3'd0, 0);

    // R8 stale synchronizer
    padIn = 8'h00;
    busWrite(3'd3, 32'h04);
    idle(5);
    busRead(3'd6, rd);
    busWrite(3'd3, 0);
    padIn = 8'h04;
    idle(5);
    check("R4 disabled pin raises nothing", irqOut, 0);
    busWrite(3'd3, 32'h04);
    idle(4);
    check("R8 stale edge raises irq on enable", irqOut, 1);
    busRead(3'd6, rd);
    check("R8 stale edge pending bit", rd, 32'h04);

    // R6 edge coinciding with status read
    busWrite(3'd3, 32'h03);
    padIn = 8'h00; idle(5);
    busRead(3'd6, rd);
    padIn = 8'h02; idle(5);
    padIn = 8'h03;
    @(posedge clk); @(negedge clk);
    @(posedge clk); @(negedge clk);
    busRead(3'd6, rd);
    check("R6 read returns prior pending", rd, 32'h02);
    check("R6 coincident edge kept", irqOut, 1);
    busRead(3'd6, rd);
    check("R6 coincident pending bit", rd, 32'h01);

    finishRun();
  end
endmodule